// File: doc/BRIEF.md
# Burst-Aligned DMA Command Fragmenter

This block turns a two-dimensional transfer request into a stream of bus commands. Each command is an address and a byte count. A request names a start address, the bytes in each array, how many arrays there are, and a signed stride between the starts of consecutive arrays. The block works through the arrays in order. It cuts each array into commands that never exceed a selectable burst limit of 16, 32 or 64 bytes.

The first command of every array is trimmed so that it ends on a burst boundary. Every command after it therefore starts aligned and can use the full burst, except the tail of the array.

Requests arrive on a valid/ready handshake, and commands leave on a second valid/ready handshake. A one-cycle done pulse marks the end of each request. The burst limit is taken from a configuration input at the moment a request is accepted.

Top module: `dma_cmd_fragmenter`

## Requirements
- R1: Every command has a byte count of at least 1 and no greater than the burst limit latched for the current request.
- R2: The burst selector encodes the limit as 0 → 16 bytes, 1 → 32 bytes, and 2 or 3 → 64 bytes.
- R3: The first command of an array carries the array's start address and a count of min(bytes per array, limit − (start address mod limit)).
- R4: Every later command in an array starts at the previous command's address plus its count. That address is a multiple of the limit. Its count is min(limit, bytes still left in the array).
- R5: Arrays are issued strictly one after another. Array k starts at the request address plus k times the sign-extended 16-bit stride, with 32-bit wraparound.
- R6: The burst selector is sampled only in the cycle a request is accepted. Changing it while the request is in progress does not affect the commands.
- R7: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_addr and cmd_bytes do not change. The block moves to the next command only after a handshake.
- R8: A request with zero bytes per array or zero arrays produces no command. done is high in the cycle after it is accepted.
- R9: req_ready is low from the cycle after acceptance until the last command's handshake. In the next cycle done is high for exactly that one cycle and req_ready is high again.
- R10: After reset, req_ready is high and cmd_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_sel | input | 2 | Burst limit code, sampled at request acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Start address of the first array |
| req_acnt | input | 16 | Bytes per array |
| req_bcnt | input | 16 | Number of arrays |
| req_stride | input | 16 | Signed distance between array starts |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_addr | output | 32 | Command start address |
| cmd_bytes | output | 7 | Command byte count |
| done | output | 1 | One-cycle pulse at the end of a request |

## Verification
The bench sweeps every burst code against start offsets on either side of a boundary, array sizes below, equal to and well above the limit, one to three arrays, and positive, negative and zero strides. It checks every command against an arithmetic model.

- A sizer that ignores the start offset gives misaligned later commands and a wrong first count.
- An off-by-one in the last-command test gives an extra command or a missing one.
- Restarting at the previous address instead of the strided base breaks the second array.

A stall pattern on cmd_ready shows whether the outputs move without a handshake. The burst selector is toggled during every request to expose a limit that is read live. Zero-sized requests check that done still arrives on time and that no command leaks out.

// File: rtl/dma_frag_pkg.sv
package dma_frag_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } frag_state_e;
endpackage

// File: rtl/burst_limit_decode.sv
module burst_limit_decode #(
    parameter int MIN_BURST = 16,
    parameter int SEL_W     = 2,
    parameter int CNT_W     = 7
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] limit
);
    localparam int MAX_SHIFT = 2;

    always_comb begin
        if (int'(sel) >= MAX_SHIFT) begin
            limit = CNT_W'(MIN_BURST << MAX_SHIFT);
        end else begin
            limit = CNT_W'(MIN_BURST << int'(sel));
        end
    end
endmodule

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
    parameter int ACNT_W = 16,
    parameter int CNT_W  = 7
) (
    input  logic [CNT_W-1:0]  addr_lo,
    input  logic [ACNT_W-1:0] remaining,
    input  logic [CNT_W-1:0]  limit,
    output logic [CNT_W-1:0]  bytes
);
    logic [CNT_W-1:0] offset;
    logic [CNT_W-1:0] room;
    logic             tail_fits;

    always_comb begin
        offset    = addr_lo & (limit - CNT_W'(1));
        room      = limit - offset;
        tail_fits = remaining < ACNT_W'(room);
        bytes     = tail_fits ? remaining[CNT_W-1:0] : room;
    end
endmodule

// File: rtl/array_stepper.sv
module array_stepper #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic [STRIDE_W-1:0] stride,
    output logic [ADDR_W-1:0]   next_base
);
    logic [ADDR_W-1:0] stride_ext;

    always_comb begin
        stride_ext = {{(ADDR_W-STRIDE_W){stride[STRIDE_W-1]}}, stride};
        next_base  = base + stride_ext;
    end
endmodule

// File: rtl/dma_cmd_fragmenter.sv
module dma_cmd_fragmenter
    import dma_frag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ACNT_W    = 16,
    parameter int BCNT_W    = 16,
    parameter int STRIDE_W  = 16,
    parameter int SEL_W     = 2,
    parameter int MIN_BURST = 16,
    parameter int MAX_BURST = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEL_W-1:0]        burst_sel,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [ACNT_W-1:0]       req_acnt,
    input  logic [BCNT_W-1:0]       req_bcnt,
    input  logic [STRIDE_W-1:0]     req_stride,
    output logic                    cmd_valid,
    input  logic                    cmd_ready,
    output logic [ADDR_W-1:0]       cmd_addr,
    output logic [$clog2(MAX_BURST):0] cmd_bytes,
    output logic                    done
);
    localparam int CNT_W = $clog2(MAX_BURST) + 1;

    typedef struct packed {
        frag_state_e         state;
        logic [ADDR_W-1:0]   base;
        logic [ADDR_W-1:0]   addr;
        logic [ACNT_W-1:0]   rem;
        logic [ACNT_W-1:0]   acnt;
        logic [BCNT_W-1:0]   left;
        logic [STRIDE_W-1:0] stride;
        logic [CNT_W-1:0]    limit;
        logic                first;
        logic                done;
    } frag_regs_t;

    frag_regs_t r_d, r_q;

    logic [CNT_W-1:0]  sel_limit;
    logic [CNT_W-1:0]  chunk_bytes;
    logic [ADDR_W-1:0] next_base;
    logic              cmd_fire;
    logic              array_end;

    burst_limit_decode #(
        .MIN_BURST (MIN_BURST),
        .SEL_W     (SEL_W),
        .CNT_W     (CNT_W)
    ) u_limit (
        .sel   (burst_sel),
        .limit (sel_limit)
    );

    chunk_sizer #(
        .ACNT_W (ACNT_W),
        .CNT_W  (CNT_W)
    ) u_sizer (
        .addr_lo   (r_q.addr[CNT_W-1:0]),
        .remaining (r_q.rem),
        .limit     (r_q.limit),
        .bytes     (chunk_bytes)
    );

    array_stepper #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W)
    ) u_step (
        .base      (r_q.base),
        .stride    (r_q.stride),
        .next_base (next_base)
    );

    assign req_ready = (r_q.state == ST_IDLE);
    assign cmd_valid = (r_q.state == ST_ISSUE);
    assign cmd_addr  = r_q.addr;
    assign cmd_bytes = chunk_bytes;
    assign done      = r_q.done;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign array_end = (r_q.rem == ACNT_W'(chunk_bytes));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_acnt == '0 || req_bcnt == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.state  = ST_ISSUE;
                        r_d.base   = req_addr;
                        r_d.addr   = req_addr;
                        r_d.rem    = req_acnt;
                        r_d.acnt   = req_acnt;
                        r_d.left   = req_bcnt;
                        r_d.stride = req_stride;
                        r_d.limit  = sel_limit;
                        r_d.first  = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (cmd_fire) begin
                    if (array_end) begin
                        if (r_q.left == BCNT_W'(1)) begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                            r_d.first = 1'b0;
                        end else begin
                            r_d.base  = next_base;
                            r_d.addr  = next_base;
                            r_d.rem   = r_q.acnt;
                            r_d.left  = r_q.left - BCNT_W'(1);
                            r_d.first = 1'b1;
                        end
                    end else begin
                        r_d.addr  = r_q.addr + ADDR_W'(chunk_bytes);
                        r_d.rem   = r_q.rem - ACNT_W'(chunk_bytes);
                        r_d.first = 1'b0;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R1
    cmd_size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_bytes != '0) && (cmd_bytes <= r_q.limit));

    // R4
    later_cmd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !r_q.first) |-> ((cmd_addr[CNT_W-1:0] & (r_q.limit - CNT_W'(1))) == '0));

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_bytes));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    // R6
    limit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(cmd_valid)) |-> $stable(r_q.limit));
endmodule

// File: tb/tb_dma_cmd_fragmenter.sv
module tb_dma_cmd_fragmenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  burst_sel = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_acnt = '0;
    logic [15:0] req_bcnt = '0;
    logic [15:0] req_stride = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [6:0]  cmd_bytes;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick = 0;
    bit finished = 0;

    logic [31:0] exp_addr [0:127];
    int          exp_len  [0:127];
    bit          exp_first[0:127];
    int          exp_n;

    always #4 clk = ~clk;

    dma_cmd_fragmenter dut (
        .clk(clk), .rst_n(rst_n), .burst_sel(burst_sel),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_acnt(req_acnt), .req_bcnt(req_bcnt), .req_stride(req_stride),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_bytes(cmd_bytes), .done(done)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int limit_of(int sel);
        return (sel == 0) ? 16 : (sel == 1) ? 32 : 64;  // R2
    endfunction

    task automatic build_model(logic [31:0] a0, int acnt, int bcnt, int stride, int lim);
        exp_n = 0;
        if (acnt == 0 || bcnt == 0) return;
        for (int k = 0; k < bcnt; k++) begin
            logic [31:0] a = a0 + 32'(k * stride);  // R5
            int rem = acnt;
            bit first = 1;
            while (rem > 0) begin
                int room = lim - int'(a % lim);
                int n = (rem < room) ? rem : room;
                exp_addr[exp_n] = a;
                exp_len[exp_n] = n;
                exp_first[exp_n] = first;
                exp_n++;
                a += 32'(n);
                rem -= n;
                first = 0;
            end
        end
    endtask

    task automatic run_req(logic [31:0] a0, int acnt, int bcnt, int stride, int sel);
        int idx = 0;
        int guard = 0;
        bit stalled = 0;
        logic [31:0] prev_addr = '0;
        logic [6:0]  prev_bytes = '0;
        build_model(a0, acnt, bcnt, stride, limit_of(sel));
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
        req_addr = a0; req_acnt = 16'(acnt); req_bcnt = 16'(bcnt);
        req_stride = 16'(stride); burst_sel = 2'(sel); req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        burst_sel = 2'(sel) ^ 2'b01;  // R6: changed mid-request
        if (exp_n == 0) begin
            check(done == 1'b1, "R8 done after empty request", done, 1);
            check(cmd_valid == 1'b0, "R8 no command", cmd_valid, 0);
            return;
        end
        while (idx < exp_n && guard < 4000) begin
            guard++;
            if (!cmd_valid) begin
                check(0, "R4 command missing", 0, 1);
                @(negedge clk);
                continue;
            end
            if (stalled) begin
                check(cmd_addr == prev_addr && cmd_bytes == prev_bytes,
                      "R7 hold under stall", cmd_addr, prev_addr);
            end
            if (exp_first[idx]) begin
                check(cmd_addr == exp_addr[idx], "R3 R5 first address", cmd_addr, exp_addr[idx]);
                check(int'(cmd_bytes) == exp_len[idx], "R3 first count", cmd_bytes, exp_len[idx]);
            end else begin
                check(cmd_addr == exp_addr[idx], "R4 address", cmd_addr, exp_addr[idx]);
                check(int'(cmd_bytes) == exp_len[idx], "R4 R1 R6 count", cmd_bytes, exp_len[idx]);
            end
            check(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
            check(done == 1'b0, "R9 no early done", done, 0);
            cmd_ready = ((tick % 3) != 1);
            tick++;
            stalled = !cmd_ready;
            prev_addr = cmd_addr;
            prev_bytes = cmd_bytes;
            @(posedge clk);
            if (cmd_ready) idx++;
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        check(done == 1'b1, "R9 done after last command", done, 1);
        check(cmd_valid == 1'b0, "R5 no extra command", cmd_valid, 0);
        check(req_ready == 1'b1, "R9 ready again", req_ready, 1);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", done, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int acnts[7] = '{1, 5, 16, 17, 40, 64, 130};
        int offs[4]  = '{0, 3, 15, 60};
        int strides[3] = '{96, -48, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
        check(cmd_valid == 1'b0, "R10 reset cmd_valid", cmd_valid, 0);
        check(done == 1'b0, "R10 reset done", done, 0);
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int a = 0; a < 7; a++)
                    for (int b = 1; b <= 3; b++)
                        for (int t = 0; t < 3; t++)
                            run_req(32'h0000_1000 + 32'(offs[o]), acnts[a], b, strides[t], s);
        run_req(32'hFFFF_FFF8, 40, 2, 16, 0);    // R5 wrap
        run_req(32'h0000_2000, 0, 3, 16, 1);     // R8 zero bytes
        run_req(32'h0000_2000, 20, 0, 16, 2);    // R8 zero arrays
        run_req(32'h0000_2000, 0, 0, 16, 0);     // R8 both zero
        run_req(32'h0000_3021, 100, 2, -200, 3); // R2 code 3
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule